// File: doc/BRIEF.md
# Wide Register Access Collector

This block sits between a host bus that moves 32-bit or 64-bit words and a bank of device registers that are 128 bits wide, plus a region of 64-bit memory entries. A register can only change all at once. The block therefore gathers the partial writes of one register in a staging buffer and releases the complete value on a commit strobe only when the slice that closes the register arrives. For a 16-byte register that slice is dword 3. For an 8-byte memory entry it is dword 1. Reads are served through a 128-bit snapshot. Reading the lowest dword of a register captures its whole current value, and later reads of the upper dwords return that same captured value even if the register has changed in between.

A short list of narrow registers (queue pointers and descriptor doorbells) is written with a single dword that takes effect at once. Such a write may fall in the middle of a half-gathered wide write without disturbing it. Addresses are split into pages of 8 KiB, and a narrow register is recognised by its offset inside any page. On page 0 a single-dword write to one of these offsets is a known hazard for the collector. It is therefore treated as an ordinary gathered write to dword 0 of its slot. The register file behind the block supplies current values through a combinational read port and applies each commit using the dword mask that comes with it.

Top module: `wide_reg_collector`

## Requirements
- R1: For a 16-byte register, dword writes to offsets 0, 4 and 8 raise no commit. A dword write to offset 12 raises `commit_valid` for one cycle, one clock after the write is accepted. It carries the 16-byte-aligned address, the gathered data and dword mask 4'b1111. No commit ever follows a cycle without a write.
- R2: A 64-bit write (`bus_qword`=1) to offset 0 of a register stages dwords 0 and 1 without a commit. A 64-bit write to offset 8 commits the register.
- R3: Addresses at or above `SRAM_BASE` form 8-byte entries. A dword write to offset 0 stages. A dword write to offset 4, or a single 64-bit write, commits with mask 4'b0011 and the 8-byte-aligned address in `commit_addr`.
- R4: A read of dword 0 (or a 64-bit read at offset 0) of a register or entry loads all 128 bits from `rd_data` into the snapshot. Reads at higher offsets return snapshot data. Narrow-register reads use `rd_data` directly and leave the snapshot unchanged.
- R5: `bus_ready` is always 1. Every read raises `bus_rvalid` exactly one cycle later with `bus_rdata`. For a dword read the upper 32 bits are zero. For a 64-bit read they hold the next dword.
- R6: A dword write to a narrow offset (by default 0x400, 0x800 or 0xC00 within a page) on page 1 or higher raises `narrow_valid` one cycle later with the address and the low 32 data bits, and raises no commit.
- R7: A narrow write between the slices of a gathered write leaves the staged dwords intact. The later commit still carries them.
- R8: On page 0 a dword write to a narrow offset raises no `narrow_valid`. It is staged as dword 0 of its slot and is committed by that slot's closing write.
- R9: A closing write to a slot other than the one being staged commits a mask that holds only the dwords of that slot actually written.
- R10: After reset no strobe is raised and the staging buffer is empty. A closing write that follows reset commits only its own dwords.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Host access request |
| bus_ready | output | 1 | Always 1, every request accepted |
| bus_write | input | 1 | 1 write, 0 read |
| bus_qword | input | 1 | 1 for a 64-bit access, 0 for 32-bit |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 64 | Write data, dword writes use the low 32 bits |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read |
| bus_rdata | output | 64 | Read data |
| rd_addr | output | ADDR_W | Aligned address presented to the register file |
| rd_data | input | 128 | Current register or entry value for `rd_addr` |
| commit_valid | output | 1 | One-cycle commit strobe |
| commit_addr | output | ADDR_W | Aligned address of the committed register or entry |
| commit_dmask | output | 4 | Dwords carried by the commit |
| commit_data | output | 128 | Committed data |
| narrow_valid | output | 1 | One-cycle narrow register write strobe |
| narrow_addr | output | ADDR_W | Narrow register address |
| narrow_data | output | 32 | Narrow register data |

## Verification
The bench builds the block with its default parameters: an 18-bit address, 8 KiB pages, the memory region from 0x20000 and three narrow offsets. That covers page 0 and higher pages of the register space, the memory region and all narrow offsets in one address map. The stimulus model derives `rd_data` from the address and a salt value. Changing the salt between reads exposes whether upper-dword reads really come from the snapshot.

// File: rtl/wrc_pkg.sv
package wrc_pkg;

  // Class of a decoded host access
  typedef enum logic [1:0] {
    ACC_WIDE       = 2'd0,  // 16-byte register, gathered
    ACC_SRAM       = 2'd1,  // 8-byte memory entry, gathered
    ACC_NARROW     = 2'd2,  // single-dword register, bypasses staging
    ACC_NARROW_HAZ = 2'd3   // narrow offset on page 0, gathered as wide
  } acc_kind_e;

  localparam int unsigned DW_W      = 32;
  localparam int unsigned SLOT_DW   = 4;
  localparam int unsigned SLOT_W    = DW_W * SLOT_DW;
  localparam int unsigned HOST_W    = 64;

endpackage

// File: rtl/wrc_decode.sv
module wrc_decode
  import wrc_pkg::*;
#(
  parameter int unsigned ADDR_W     = 18,
  parameter int unsigned PAGE_SHIFT = 13,
  parameter logic [ADDR_W-1:0] SRAM_BASE = 18'h20000,
  parameter int unsigned NUM_NARROW = 3,
  parameter logic [NUM_NARROW*PAGE_SHIFT-1:0] NARROW_OFS =
    {13'h0C00, 13'h0800, 13'h0400}
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_qword,
  output acc_kind_e         kind,
  output logic [ADDR_W-1:0] slot_addr,
  output logic [1:0]        dw_idx
);

  localparam int unsigned PAGE_W = ADDR_W - PAGE_SHIFT;

  logic                  in_sram;
  logic                  page_zero;
  logic [PAGE_SHIFT-1:0] page_ofs;
  logic [NUM_NARROW-1:0] ofs_hit;
  logic [1:0]            raw_idx;

  assign in_sram   = (addr >= SRAM_BASE);
  assign page_zero = (addr[ADDR_W-1:PAGE_SHIFT] == PAGE_W'(0));
  assign page_ofs  = addr[PAGE_SHIFT-1:0];

  generate
    for (genvar i = 0; i < NUM_NARROW; i++) begin : g_narrow_cmp
      assign ofs_hit[i] = (page_ofs == NARROW_OFS[i*PAGE_SHIFT +: PAGE_SHIFT]);
    end
  endgenerate

  always_comb begin
    if (in_sram) begin
      slot_addr = {addr[ADDR_W-1:3], 3'b000};
      raw_idx   = {1'b0, addr[2]};
    end else begin
      slot_addr = {addr[ADDR_W-1:4], 4'b0000};
      raw_idx   = addr[3:2];
    end
    // 64-bit accesses are always qword aligned
    dw_idx = {raw_idx[1], raw_idx[0] & ~is_qword};

    if (!in_sram && !is_qword && (|ofs_hit)) begin
      kind = page_zero ? ACC_NARROW_HAZ : ACC_NARROW;
    end else if (in_sram) begin
      kind = ACC_SRAM;
    end else begin
      kind = ACC_WIDE;
    end
  end

endmodule

// File: rtl/wrc_write_collect.sv
module wrc_write_collect
  import wrc_pkg::*;
#(
  parameter int unsigned ADDR_W = 18
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_fire,
  input  acc_kind_e           kind,
  input  logic [ADDR_W-1:0]   slot_addr,
  input  logic [1:0]          dw_idx,
  input  logic                is_qword,
  input  logic [HOST_W-1:0]   wdata,
  output logic                commit_valid,
  output logic [ADDR_W-1:0]   commit_addr,
  output logic [SLOT_DW-1:0]  commit_dmask,
  output logic [SLOT_W-1:0]   commit_data,
  output logic                narrow_valid,
  output logic [ADDR_W-1:0]   narrow_addr,
  output logic [DW_W-1:0]     narrow_data
);

  // staging state
  logic [SLOT_DW-1:0][DW_W-1:0] stage_data, stage_data_n;
  logic [SLOT_DW-1:0]           stage_mask, stage_mask_n;
  logic [ADDR_W-1:0]            stage_slot, stage_slot_n;

  // comb helpers
  logic [SLOT_DW-1:0][DW_W-1:0] new_dw, merged_dw;
  logic [SLOT_DW-1:0]           new_mask, base_mask, out_mask;
  logic [1:0]                   last_idx;
  logic                         collect, same_slot, do_commit, narrow_fire;
  logic                         stage_en;

  assign new_mask    = is_qword ? (4'b0011 << dw_idx) : (4'b0001 << dw_idx);
  assign last_idx    = (kind == ACC_SRAM) ? 2'd1 : 2'd3;
  assign narrow_fire = wr_fire && (kind == ACC_NARROW);
  assign collect     = wr_fire && (kind != ACC_NARROW);
  assign same_slot   = (stage_mask != '0) && (stage_slot == slot_addr);
  assign base_mask   = same_slot ? stage_mask : '0;
  assign out_mask    = base_mask | new_mask;
  assign do_commit   = collect && new_mask[last_idx];
  assign stage_en    = collect;

  generate
    for (genvar k = 0; k < SLOT_DW; k++) begin : g_lane
      assign new_dw[k]    = (dw_idx == 2'(k)) ? wdata[DW_W-1:0] : wdata[HOST_W-1:DW_W];
      assign merged_dw[k] = new_mask[k] ? new_dw[k] : stage_data[k];
    end
  endgenerate

  // next state of the staging buffer
  always_comb begin
    stage_data_n = stage_data;
    stage_mask_n = stage_mask;
    stage_slot_n = stage_slot;
    if (do_commit) begin
      stage_mask_n = '0;
    end else begin
      stage_data_n = merged_dw;
      stage_mask_n = out_mask;
      stage_slot_n = slot_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_data <= '0;
      stage_mask <= '0;
      stage_slot <= '0;
    end else if (stage_en) begin
      stage_data <= stage_data_n;
      stage_mask <= stage_mask_n;
      stage_slot <= stage_slot_n;
    end
  end

  // commit strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit_valid <= 1'b0;
    end else begin
      commit_valid <= do_commit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit_addr  <= '0;
      commit_dmask <= '0;
      commit_data  <= '0;
    end else if (do_commit) begin
      commit_addr  <= slot_addr;
      commit_dmask <= out_mask;
      commit_data  <= merged_dw;
    end
  end

  // narrow bypass
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      narrow_valid <= 1'b0;
    end else begin
      narrow_valid <= narrow_fire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      narrow_addr <= '0;
      narrow_data <= '0;
    end else if (narrow_fire) begin
      narrow_addr <= slot_addr;
      narrow_data <= wdata[DW_W-1:0];
    end
  end

  // R1
  commit_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> !commit_valid);

  // R7
  narrow_keeps_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    narrow_fire |=> ($stable(stage_mask) && $stable(stage_slot) && $stable(stage_data)));

  // R6
  narrow_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    narrow_fire |=> (narrow_valid && !commit_valid));

endmodule

// File: rtl/wrc_read_shadow.sv
module wrc_read_shadow
  import wrc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_fire,
  input  acc_kind_e           kind,
  input  logic [1:0]          dw_idx,
  input  logic                is_qword,
  input  logic [SLOT_W-1:0]   rd_data,
  output logic                rvalid,
  output logic [HOST_W-1:0]   rdata
);

  logic [SLOT_DW-1:0][DW_W-1:0] shadow_q;
  logic [SLOT_DW-1:0][DW_W-1:0] src;
  logic [HOST_W-1:0]            rdata_n;
  logic                         direct, load;
  logic [DW_W-1:0]              lo_dw, hi_dw;

  assign direct = (kind == ACC_NARROW) || (kind == ACC_NARROW_HAZ);
  assign load   = rd_fire && !direct && (dw_idx == 2'd0);

  always_comb begin
    if (direct || (dw_idx == 2'd0)) begin
      src = rd_data;
    end else begin
      src = shadow_q;
    end
    lo_dw   = src[dw_idx];
    hi_dw   = src[{dw_idx[1], 1'b1}];
    rdata_n = is_qword ? {hi_dw, lo_dw} : {{DW_W{1'b0}}, lo_dw};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
    end else if (load) begin
      shadow_q <= rd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_fire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_fire) begin
      rdata <= rdata_n;
    end
  end

  // R4
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && (direct || dw_idx != 2'd0)) |=> $stable(shadow_q));

  // R5
  read_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rvalid);

  // R5
  no_spurious_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> !rvalid);

endmodule

// File: rtl/wide_reg_collector.sv
module wide_reg_collector
  import wrc_pkg::*;
#(
  parameter int unsigned ADDR_W     = 18,
  parameter int unsigned PAGE_SHIFT = 13,
  parameter logic [ADDR_W-1:0] SRAM_BASE = 18'h20000,
  parameter int unsigned NUM_NARROW = 3,
  parameter logic [NUM_NARROW*PAGE_SHIFT-1:0] NARROW_OFS =
    {13'h0C00, 13'h0800, 13'h0400}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic              bus_qword,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [63:0]       bus_wdata,
  output logic              bus_rvalid,
  output logic [63:0]       bus_rdata,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [127:0]      rd_data,
  output logic              commit_valid,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [3:0]        commit_dmask,
  output logic [127:0]      commit_data,
  output logic              narrow_valid,
  output logic [ADDR_W-1:0] narrow_addr,
  output logic [31:0]       narrow_data
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[1];

  acc_kind_e         kind;
  logic [ADDR_W-1:0] slot_addr;
  logic [1:0]        dw_idx;
  logic              wr_fire, rd_fire;

  assign bus_ready = 1'b1;
  assign wr_fire   = bus_valid && bus_write;
  assign rd_fire   = bus_valid && !bus_write;
  assign rd_addr   = slot_addr;

  wrc_decode #(
    .ADDR_W     (ADDR_W),
    .PAGE_SHIFT (PAGE_SHIFT),
    .SRAM_BASE  (SRAM_BASE),
    .NUM_NARROW (NUM_NARROW),
    .NARROW_OFS (NARROW_OFS)
  ) u_decode (
    .addr      (bus_addr),
    .is_qword  (bus_qword),
    .kind      (kind),
    .slot_addr (slot_addr),
    .dw_idx    (dw_idx)
  );

  wrc_write_collect #(
    .ADDR_W (ADDR_W)
  ) u_collect (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .wr_fire      (wr_fire),
    .kind         (kind),
    .slot_addr    (slot_addr),
    .dw_idx       (dw_idx),
    .is_qword     (bus_qword),
    .wdata        (bus_wdata),
    .commit_valid (commit_valid),
    .commit_addr  (commit_addr),
    .commit_dmask (commit_dmask),
    .commit_data  (commit_data),
    .narrow_valid (narrow_valid),
    .narrow_addr  (narrow_addr),
    .narrow_data  (narrow_data)
  );

  wrc_read_shadow u_shadow (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .rd_fire  (rd_fire),
    .kind     (kind),
    .dw_idx   (dw_idx),
    .is_qword (bus_qword),
    .rd_data  (rd_data),
    .rvalid   (bus_rvalid),
    .rdata    (bus_rdata)
  );

  // R8
  hazard_no_bypass_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_fire && kind == ACC_NARROW_HAZ) |=> !narrow_valid);

  // R6
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(narrow_valid && commit_valid));

endmodule

// File: tb/wide_reg_collector_bench.sv
`timescale 1ns/1ps
module wide_reg_collector_bench;

  localparam int ADDR_W = 18;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              bus_valid, bus_write, bus_qword;
  logic [ADDR_W-1:0] bus_addr;
  logic [63:0]       bus_wdata;
  logic              bus_ready, bus_rvalid;
  logic [63:0]       bus_rdata;
  logic [ADDR_W-1:0] rd_addr;
  logic [127:0]      rd_data;
  logic              commit_valid, narrow_valid;
  logic [ADDR_W-1:0] commit_addr, narrow_addr;
  logic [3:0]        commit_dmask;
  logic [127:0]      commit_data;
  logic [31:0]       narrow_data;
  logic [31:0]       salt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  wide_reg_collector u_wide_reg_collector (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_qword(bus_qword), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
    .rd_addr(rd_addr), .rd_data(rd_data), .commit_valid(commit_valid),
    .commit_addr(commit_addr), .commit_dmask(commit_dmask),
    .commit_data(commit_data), .narrow_valid(narrow_valid),
    .narrow_addr(narrow_addr), .narrow_data(narrow_data)
  );

  // register file stand-in: value depends on address and salt
  function automatic logic [127:0] model(input logic [ADDR_W-1:0] a, input logic [31:0] s);
    logic [127:0] v;
    for (int k = 0; k < 4; k++) begin
      v[k*32 +: 32] = s ^ {14'h0, a} ^ (32'h01010101 * (k + 1));
    end
    return v;
  endfunction

  always_comb rd_data = model(rd_addr, salt);

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] expand(input logic [3:0] m);
    logic [127:0] r;
    for (int k = 0; k < 4; k++) r[k*32 +: 32] = {32{m[k]}};
    return r;
  endfunction

  task automatic bus_op(input logic wr, input logic qw, input logic [ADDR_W-1:0] a,
                        input logic [63:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_qword = qw; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  typedef struct packed {
    logic              qw;
    logic [ADDR_W-1:0] addr;
    logic [63:0]       wdata;
    logic              cv;
    logic [3:0]        mask;
    logic [ADDR_W-1:0] caddr;
    logic [127:0]      cdata;
    logic              nv;
    logic [3:0]        req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    // R1 gather dwords 0..2, R6/R7 narrow in the middle
    '{1'b0, 18'h02010, 64'h11111111, 1'b0, 4'h0, 18'h0, 128'h0, 1'b0, 4'd1},
    '{1'b0, 18'h02014, 64'h22222222, 1'b0, 4'h0, 18'h0, 128'h0, 1'b0, 4'd1},
    '{1'b0, 18'h02400, 64'hCAFE0001, 1'b0, 4'h0, 18'h0, 128'h0, 1'b1, 4'd6},
    '{1'b0, 18'h02018, 64'h33333333, 1'b0, 4'h0, 18'h0, 128'h0, 1'b0, 4'd1},
    '{1'b0, 18'h0201C, 64'h44444444, 1'b1, 4'hF, 18'h02010,
      128'h44444444_33333333_22222222_11111111, 1'b0, 4'd7},
    // R2 qword pair
    '{1'b1, 18'h02010, 64'h66666666_55555555, 1'b0, 4'h0, 18'h0, 128'h0, 1'b0, 4'd2},
    '{1'b1, 18'h02018, 64'h88888888_77777777, 1'b1, 4'hF, 18'h02010,
      128'h88888888_77777777_66666666_55555555, 1'b0, 4'd2},
    // R3 memory entries
    '{1'b0, 18'h20028, 64'h9999AAAA, 1'b0, 4'h0, 18'h0, 128'h0, 1'b0, 4'd3},
    '{1'b0, 18'h2002C, 64'hBBBBCCCC, 1'b1, 4'h3, 18'h20028,
      {64'h0, 64'hBBBBCCCC_9999AAAA}, 1'b0, 4'd3},
    '{1'b1, 18'h20030, 64'hDDDDDDDD_EEEEEEEE, 1'b1, 4'h3, 18'h20030,
      {64'h0, 64'hDDDDDDDD_EEEEEEEE}, 1'b0, 4'd3},
    // R8 page-0 narrow offset is gathered
    '{1'b0, 18'h00400, 64'h0000ABCD, 1'b0, 4'h0, 18'h0, 128'h0, 1'b0, 4'd8},
    '{1'b0, 18'h0040C, 64'h12345678, 1'b1, 4'h9, 18'h00400,
      128'h12345678_00000000_00000000_0000ABCD, 1'b0, 4'd8},
    // R9 closing write to another slot
    '{1'b0, 18'h02024, 64'h0B0B0B0B, 1'b0, 4'h0, 18'h0, 128'h0, 1'b0, 4'd9},
    '{1'b0, 18'h0203C, 64'h0C0C0C0C, 1'b1, 4'h8, 18'h02030,
      128'h0C0C0C0C_00000000_00000000_00000000, 1'b0, 4'd9},
    // R6 narrow on page 3
    '{1'b0, 18'h06800, 64'h00000077, 1'b0, 4'h0, 18'h0, 128'h0, 1'b1, 4'd6}
  };

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    logic [127:0] snap;
    string tag;
    rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; bus_qword = 1'b0;
    bus_addr = '0; bus_wdata = '0; salt = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    check("R10 commit_valid", {127'h0, commit_valid}, 128'h0);
    check("R10 narrow_valid", {127'h0, narrow_valid}, 128'h0);
    check("R10 bus_rvalid",   {127'h0, bus_rvalid},   128'h0);
    check("R5 bus_ready",     {127'h0, bus_ready},    128'h1);

    // table walk
    for (int i = 0; i < NV; i++) begin
      bus_op(1'b1, VEC[i].qw, VEC[i].addr, VEC[i].wdata);
      tag = $sformatf("R%0d row%0d", VEC[i].req, i);
      check({tag, " commit_valid"}, {127'h0, commit_valid}, {127'h0, VEC[i].cv});
      check({tag, " narrow_valid"}, {127'h0, narrow_valid}, {127'h0, VEC[i].nv});
      if (VEC[i].cv) begin
        check({tag, " commit_dmask"}, {124'h0, commit_dmask}, {124'h0, VEC[i].mask});
        check({tag, " commit_addr"},  {110'h0, commit_addr},  {110'h0, VEC[i].caddr});
        check({tag, " commit_data"},  commit_data & expand(VEC[i].mask),
              VEC[i].cdata & expand(VEC[i].mask));
      end
      if (VEC[i].nv) begin
        check({tag, " narrow_addr"}, {110'h0, narrow_addr}, {110'h0, VEC[i].addr});
        check({tag, " narrow_data"}, {96'h0, narrow_data}, {96'h0, VEC[i].wdata[31:0]});
      end
    end

    // R4 / R5 snapshot reads
    salt = 32'h10000000;
    snap = model(18'h02010, salt);
    bus_op(1'b0, 1'b0, 18'h02010, 64'h0);
    check("R5 rvalid after read", {127'h0, bus_rvalid}, 128'h1);
    check("R4 dword0 read", {64'h0, bus_rdata}, {96'h0, snap[31:0]});
    @(negedge clk);
    check("R5 rvalid drops", {127'h0, bus_rvalid}, 128'h0);
    salt = 32'h22220000;
    bus_op(1'b0, 1'b0, 18'h02014, 64'h0);
    check("R4 dword1 from snapshot", {64'h0, bus_rdata}, {96'h0, snap[63:32]});
    bus_op(1'b0, 1'b1, 18'h02018, 64'h0);
    check("R4 qword upper from snapshot", {64'h0, bus_rdata}, {64'h0, snap[127:64]});
    // R4 narrow read is direct and leaves the snapshot alone
    bus_op(1'b0, 1'b0, 18'h02400, 64'h0);
    check("R4 narrow read direct", {64'h0, bus_rdata},
          {96'h0, model(18'h02400, salt)[31:0]});
    bus_op(1'b0, 1'b0, 18'h0201C, 64'h0);
    check("R4 snapshot kept", {64'h0, bus_rdata}, {96'h0, snap[127:96]});
    bus_op(1'b0, 1'b1, 18'h02010, 64'h0);
    check("R4 qword0 reloads", {64'h0, bus_rdata},
          {64'h0, model(18'h02010, salt)[63:0]});
    // R3/R4 memory entry snapshot
    snap = model(18'h20028, salt);
    bus_op(1'b0, 1'b0, 18'h20028, 64'h0);
    salt = 32'h33330000;
    bus_op(1'b0, 1'b0, 18'h2002C, 64'h0);
    check("R4 entry dword1 from snapshot", {64'h0, bus_rdata}, {96'h0, snap[63:32]});

    // R10 reset empties staging
    bus_op(1'b1, 1'b0, 18'h02050, 64'hAAAA0000);
    do_reset();
    bus_op(1'b1, 1'b0, 18'h0205C, 64'hBBBB0000);
    check("R10 commit after reset", {127'h0, commit_valid}, 128'h1);
    check("R10 mask after reset", {124'h0, commit_dmask}, 128'h8);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule